// File: doc/BRIEF.md
# GPIO Edge Interrupt Flag Unit

This block watches three general-purpose input ports: two 8-bit ports (A and B) and one 5-bit port (C). Each pin passes through a two-flop synchroniser and then an edge detector. When the selected edge is seen, the pin's status flag is set and stays set until software clears it. A flag is recorded whether or not the pin's interrupt enable bit is set. Each port raises its interrupt request while any pin has both its flag and its enable set.

Ports A and B also produce a DMA trigger. This is a one-cycle pulse, issued when an enabled pin flag of that port goes from 0 to 1. Software reaches the enable, edge-configuration and flag registers through a simple register bus. Writes are strobed and reads are combinational. Software clears a flag by writing 0 to its bit. Writing 1 leaves the flag as it was, so an interrupt handler can clear the pins it has serviced without disturbing the others.

The register decoder is an enumerated address type, decoded with `unique case`. Address 0 holds enable A, 1 enable B, 2 enable C, 3 the edge configuration, 4 flag A, 5 flag B and 6 flag C. Address 7 is unmapped.

Top module: `gpio_edge_irq`

## Requirements
- R1: A pin's flag becomes 1 when its selected edge is detected, whether or not that pin's enable bit is set.
- R2: Writing the flag register of a port clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged. Without a write, a flag never clears.
- R3: The edge register (address 3, bits 3:0) selects the edge: 0 means rising and 1 means falling. Bit 0 serves port A, bit 1 serves port B pins 3:0, bit 2 serves port B pins 7:4 and bit 3 serves port C. Reading address 3 returns these four bits.
- R4: Bit n of `irq` (n = 0 for A, 1 for B, 2 for C) is 1 exactly while that port has at least one pin with both its flag and its enable set. It drops in the clock after the last such flag is cleared, even if flags of disabled pins remain set.
- R5: `dma_trig[0]` (port A) and `dma_trig[1]` (port B) each pulse high for exactly one cycle when an edge sets a flag that was 0 on an enabled pin of that port. There is no pulse for an edge on a pin whose flag is already set, or on a disabled pin.
- R6: When an edge and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R7: A pin change driven before clock edge k shows in the flag register after clock edge k+2, and not after edge k+1.
- R8: After reset, every register reads 0, `irq` is 0 and `dma_trig` is 0. Address 7 always reads 0.
- R9: Enable registers read back what was written, limited to the port width. Port C bits 7:5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pa_in | input | 8 | Port A pins, asynchronous |
| pb_in | input | 8 | Port B pins, asynchronous |
| pc_in | input | 5 | Port C pins, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr, combinational |
| irq | output | 3 | Interrupt request per port: C, B, A |
| dma_trig | output | 2 | One-cycle DMA trigger: B, A |

## Verification
The bench collides an edge with a clearing write in the same cycle. A design that lets the write win would lose the event and read back 0. It raises flags on disabled pins and then clears the enabled ones. A request built from raw flags rather than enabled flags would leave `irq` high. It sends repeated edges to a pin whose flag is still set, and an edge to a disabled pin. A trigger taken from the raw edge would pulse again in both cases. It splits port B's edge selection by nibble, and reads the flag register one cycle before and one cycle after the expected latency. A synchroniser that is one stage short or one stage long would show up in that latency check.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int CFG_W  = 4;

    // edge-select bit positions inside the configuration register
    localparam int CFG_A    = 0;
    localparam int CFG_B_LO = 1;
    localparam int CFG_B_HI = 2;
    localparam int CFG_C    = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_EN_A  = 3'd0,
        RA_EN_B  = 3'd1,
        RA_EN_C  = 3'd2,
        RA_EDGE  = 3'd3,
        RA_FLG_A = 3'd4,
        RA_FLG_B = 3'd5,
        RA_FLG_C = 3'd6
    } reg_addr_e;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] fall,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur;
    end

    // falling where selected, rising elsewhere
    assign hit = (fall & prev_q & ~cur) | (~fall & cur & ~prev_q);

    // a detected edge means the level moved since the previous cycle
    AST_HIT_AFTER_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |-> ((cur ^ $past(cur)) & hit) == hit); // R3
endmodule

// File: rtl/gpio_port_flags.sv
module gpio_port_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hit,
    input  logic         en_we,
    input  logic         flg_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q,
    output logic [W-1:0] flag_q,
    output logic         irq
);
    logic [W-1:0] keep_mask;

    // a write keeps only the ones it carries; no write keeps everything
    assign keep_mask = flg_we ? wdata : '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            flag_q <= '0;
        end else begin
            if (en_we) en_q <= wdata;
            flag_q <= (flag_q & keep_mask) | hit;   // edge wins over clear
        end
    end

    assign irq = |(flag_q & en_q);

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((flag_q & $past(hit)) == $past(hit))); // R1

    AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !flg_we |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R2

    AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        flg_we |=> ((flag_q & $past(flag_q & wdata)) == $past(flag_q & wdata))); // R2

    AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_we && wdata == '0 && hit == '0) |=> !irq); // R4

    AST_COLLIDE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_we && hit != '0) |=> ((flag_q & $past(hit)) != '0)); // R6
endmodule

// File: rtl/gpio_dma_pulse.sv
module gpio_dma_pulse #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hit,
    input  logic [W-1:0] en,
    input  logic [W-1:0] flag,
    output logic         dma
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dma <= 1'b0;
        else        dma <= |(hit & en & ~flag);
    end

    AST_DMA_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        dma |-> ((flag & $past(en)) != '0)); // R5

    AST_DMA_WAS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        dma |-> ($past(flag) != flag)); // R5
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_irq_pkg::*;
#(
    parameter int PA_W = 8,
    parameter int PB_W = 8,
    parameter int PC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PA_W-1:0]   pa_in,
    input  logic [PB_W-1:0]   pb_in,
    input  logic [PC_W-1:0]   pc_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [2:0]        irq,
    output logic [1:0]        dma_trig
);
    localparam int PB_HALF = PB_W / 2;

    logic [CFG_W-1:0] cfg_q;
    logic             cfg_we;
    logic [2:0]       en_we;
    logic [2:0]       flg_we;

    logic [PA_W-1:0] sa, fall_a, hit_a, en_a, flg_a;
    logic [PB_W-1:0] sb, fall_b, hit_b, en_b, flg_b;
    logic [PC_W-1:0] sc, fall_c, hit_c, en_c, flg_c;

    // ---------------- register write decode ----------------
    always_comb begin
        cfg_we = 1'b0;
        en_we  = '0;
        flg_we = '0;
        if (bus_we) begin
            unique case (reg_addr_e'(bus_addr))
                RA_EN_A:  en_we[0]  = 1'b1;
                RA_EN_B:  en_we[1]  = 1'b1;
                RA_EN_C:  en_we[2]  = 1'b1;
                RA_EDGE:  cfg_we    = 1'b1;
                RA_FLG_A: flg_we[0] = 1'b1;
                RA_FLG_B: flg_we[1] = 1'b1;
                RA_FLG_C: flg_we[2] = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= bus_wdata[CFG_W-1:0];
    end

    // ---------------- per-pin edge selection ----------------
    assign fall_a = {PA_W{cfg_q[CFG_A]}};
    assign fall_c = {PC_W{cfg_q[CFG_C]}};

    generate
        for (genvar gi = 0; gi < PB_W; gi++) begin : g_fall_b
            if (gi < PB_HALF) begin : g_lo
                assign fall_b[gi] = cfg_q[CFG_B_LO];
            end else begin : g_hi
                assign fall_b[gi] = cfg_q[CFG_B_HI];
            end
        end
    endgenerate

    // ---------------- port A ----------------
    gpio_sync2 #(.W(PA_W)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .d(pa_in), .q(sa));
    gpio_edge_det #(.W(PA_W)) u_edge_a (
        .clk(clk), .rst_n(rst_n), .cur(sa), .fall(fall_a), .hit(hit_a));
    gpio_port_flags #(.W(PA_W)) u_flag_a (
        .clk(clk), .rst_n(rst_n), .hit(hit_a), .en_we(en_we[0]),
        .flg_we(flg_we[0]), .wdata(bus_wdata[PA_W-1:0]),
        .en_q(en_a), .flag_q(flg_a), .irq(irq[0]));
    gpio_dma_pulse #(.W(PA_W)) u_dma_a (
        .clk(clk), .rst_n(rst_n), .hit(hit_a), .en(en_a), .flag(flg_a),
        .dma(dma_trig[0]));

    // ---------------- port B ----------------
    gpio_sync2 #(.W(PB_W)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .d(pb_in), .q(sb));
    gpio_edge_det #(.W(PB_W)) u_edge_b (
        .clk(clk), .rst_n(rst_n), .cur(sb), .fall(fall_b), .hit(hit_b));
    gpio_port_flags #(.W(PB_W)) u_flag_b (
        .clk(clk), .rst_n(rst_n), .hit(hit_b), .en_we(en_we[1]),
        .flg_we(flg_we[1]), .wdata(bus_wdata[PB_W-1:0]),
        .en_q(en_b), .flag_q(flg_b), .irq(irq[1]));
    gpio_dma_pulse #(.W(PB_W)) u_dma_b (
        .clk(clk), .rst_n(rst_n), .hit(hit_b), .en(en_b), .flag(flg_b),
        .dma(dma_trig[1]));

    // ---------------- port C ----------------
    gpio_sync2 #(.W(PC_W)) u_sync_c (
        .clk(clk), .rst_n(rst_n), .d(pc_in), .q(sc));
    gpio_edge_det #(.W(PC_W)) u_edge_c (
        .clk(clk), .rst_n(rst_n), .cur(sc), .fall(fall_c), .hit(hit_c));
    gpio_port_flags #(.W(PC_W)) u_flag_c (
        .clk(clk), .rst_n(rst_n), .hit(hit_c), .en_we(en_we[2]),
        .flg_we(flg_we[2]), .wdata(bus_wdata[PC_W-1:0]),
        .en_q(en_c), .flag_q(flg_c), .irq(irq[2]));

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        unique case (reg_addr_e'(bus_addr))
            RA_EN_A:  bus_rdata[PA_W-1:0]  = en_a;
            RA_EN_B:  bus_rdata[PB_W-1:0]  = en_b;
            RA_EN_C:  bus_rdata[PC_W-1:0]  = en_c;
            RA_EDGE:  bus_rdata[CFG_W-1:0] = cfg_q;
            RA_FLG_A: bus_rdata[PA_W-1:0]  = flg_a;
            RA_FLG_B: bus_rdata[PB_W-1:0]  = flg_b;
            RA_FLG_C: bus_rdata[PC_W-1:0]  = flg_c;
            default:  bus_rdata = '0;
        endcase
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd7) |-> (bus_rdata == '0)); // R8
endmodule

// File: tb/gpio_edge_irq_test.sv
`timescale 1ns/1ps
module gpio_edge_irq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pa = '0;
    logic [7:0] pb = '0;
    logic [4:0] pc = '0;
    logic       we = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] irq;
    logic [1:0] dma;

    int checks = 0;
    int errors = 0;
    int dma_cnt0 = 0;
    int dma_cnt1 = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    gpio_edge_irq uut (
        .clk(clk), .rst_n(rst_n), .pa_in(pa), .pb_in(pb), .pc_in(pc),
        .bus_we(we), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq(irq), .dma_trig(dma));

    always @(negedge clk) begin
        if (rst_n) begin
            if (dma[0]) dma_cnt0++;
            if (dma[1]) dma_cnt1++;
        end
    end

    // entry: {req[3:0], op[1:0], addr[2:0], data[20:0]}
    // op 0 = write data[7:0]; 1 = drive pins {C,B,A}; 2 = read, expect data[7:0]
    localparam int N_VEC = 27;
    localparam logic [29:0] TBL [N_VEC] = '{
        {4'd8, 2'd2, 3'd0, 21'h00},                       // R8 reset enable A
        {4'd8, 2'd2, 3'd3, 21'h00},                       // R8 reset edge cfg
        {4'd8, 2'd2, 3'd4, 21'h00},                       // R8 reset flag A
        {4'd1, 2'd1, 3'd0, {5'h00, 8'h00, 8'h01}},        // R1 rise A0, not enabled
        {4'd1, 2'd2, 3'd4, 21'h01},                       // R1 flag latched
        {4'd9, 2'd0, 3'd0, 21'h01},
        {4'd9, 2'd2, 3'd0, 21'h01},                       // R9 enable readback
        {4'd2, 2'd0, 3'd4, 21'hFF},
        {4'd2, 2'd2, 3'd4, 21'h01},                       // R2 write 1 keeps
        {4'd2, 2'd0, 3'd4, 21'hFE},
        {4'd2, 2'd2, 3'd4, 21'h00},                       // R2 write 0 clears
        {4'd3, 2'd0, 3'd3, 21'h01},                       // R3 port A falling
        {4'd3, 2'd1, 3'd0, {5'h00, 8'h00, 8'h00}},
        {4'd3, 2'd2, 3'd4, 21'h01},                       // R3 falling edge flagged
        {4'd3, 2'd1, 3'd0, {5'h00, 8'h00, 8'h02}},
        {4'd3, 2'd2, 3'd4, 21'h01},                       // R3 rising ignored
        {4'd3, 2'd0, 3'd3, 21'h04},                       // R3 B high nibble falling
        {4'd3, 2'd1, 3'd0, {5'h00, 8'hFF, 8'h02}},
        {4'd3, 2'd2, 3'd5, 21'h0F},                       // R3 only low nibble rose
        {4'd3, 2'd1, 3'd0, {5'h00, 8'h00, 8'h02}},
        {4'd3, 2'd2, 3'd5, 21'hFF},                       // R3 high nibble fell
        {4'd1, 2'd1, 3'd0, {5'h1F, 8'h00, 8'h02}},
        {4'd1, 2'd2, 3'd6, 21'h1F},                       // R1 port C
        {4'd9, 2'd0, 3'd2, 21'hFF},
        {4'd9, 2'd2, 3'd2, 21'h1F},                       // R9 port C width
        {4'd8, 2'd2, 3'd7, 21'h00},                       // R8 unmapped
        {4'd3, 2'd2, 3'd3, 21'h04}                        // R3 cfg readback
    };

    task automatic chk(input int req, input logic [7:0] got, input logic [7:0] exp,
                       input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_check(input int req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, rdata, exp, $sformatf("read addr %0d", a));
    endtask

    task automatic drive_pins(input logic [20:0] v, input int settle);
        @(negedge clk);
        pa = v[7:0]; pb = v[15:8]; pc = v[20:16];
        repeat (settle) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(8, {5'd0, irq}, 8'h00, "irq after reset");
        chk(8, {6'd0, dma}, 8'h00, "dma after reset");

        for (int i = 0; i < N_VEC; i++) begin
            logic [29:0] e;
            e = TBL[i];
            case (e[25:24])
                2'd0: bus_write(e[23:21], e[7:0]);
                2'd1: drive_pins(e[20:0], 3);
                default: bus_check(int'(e[29:26]), e[23:21], e[7:0]);
            endcase
        end

        // R4: A has enabled flag, B flags all disabled, C enabled flags
        #1;
        chk(4, {5'd0, irq}, 8'b101, "irq with disabled B flags");
        bus_write(3'd4, 8'h00);
        #1;
        chk(4, {5'd0, irq}, 8'b100, "irq A drops after clear");
        bus_write(3'd6, 8'h00);
        #1;
        chk(4, {5'd0, irq}, 8'b000, "irq C drops, B flags still set");

        // R5: DMA pulses (cfg = 4: A rising, B low nibble rising)
        dma_cnt0 = 0; dma_cnt1 = 0;
        drive_pins({5'h1F, 8'h00, 8'h03}, 4);
        chk(5, dma_cnt0[7:0], 8'd1, "dma A single pulse on new enabled flag");
        chk(5, dma_cnt1[7:0], 8'd0, "dma B quiet");
        drive_pins({5'h1F, 8'h00, 8'h02}, 3);
        drive_pins({5'h1F, 8'h00, 8'h03}, 4);
        chk(5, dma_cnt0[7:0], 8'd1, "no dma when flag already set");
        drive_pins({5'h1F, 8'h00, 8'h01}, 3);
        drive_pins({5'h1F, 8'h00, 8'h03}, 4);
        chk(5, dma_cnt0[7:0], 8'd1, "no dma on disabled pin");
        bus_write(3'd1, 8'h01);
        bus_write(3'd5, 8'h00);
        drive_pins({5'h1F, 8'h01, 8'h03}, 4);
        chk(5, dma_cnt1[7:0], 8'd1, "dma B single pulse");
        chk(5, dma_cnt0[7:0], 8'd1, "dma A unchanged by port B");

        // R6: edge and clearing write hit flag C0 in the same cycle
        drive_pins({5'h1E, 8'h01, 8'h03}, 3);
        @(negedge clk);
        pc = 5'h1F;                 // n0
        @(negedge clk);             // n1
        @(negedge clk);             // n2
        we = 1'b1; addr = 3'd6; wdata = 8'h00;
        @(negedge clk);             // n3
        we = 1'b0;
        bus_check(6, 3'd6, 8'h01);

        // R7: latency of pin change to flag, A bit 2
        @(negedge clk);
        pa = 8'h07;
        addr = 3'd4;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk(7, rdata, 8'h03, "flag not yet visible after two edges");
        @(negedge clk);
        #1;
        chk(7, rdata, 8'h07, "flag visible after third edge");

        // R8: reset clears everything
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(8, {5'd0, irq}, 8'h00, "irq in reset");
        addr = 3'd0; #1; chk(8, rdata, 8'h00, "enable A in reset");
        addr = 3'd3; #1; chk(8, rdata, 8'h00, "edge cfg in reset");
        addr = 3'd5; #1; chk(8, rdata, 8'h00, "flag B in reset");

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule